// File: doc/BRIEF.md
# Symmetric Folded FIR Decimator

This block is a finite impulse response filter for coefficient sets that are mirror-symmetric or mirror-antisymmetric about their centre. It accepts one sample per clock and emits one filtered sample for every two it takes in, so it serves as one branch of a two-band analysis stage. Only the first half of the coefficient set is supplied. The filter mirrors it, with or without a sign change, to form the full impulse response.

Pairs of history samples that meet the same coefficient are first combined in a pre-adder, or a pre-subtractor for the antisymmetric kind. Each folded value is captured once per output. A row of identical cells then does the products over two clocks. Each cell owns one multiplier. It takes one coefficient on the first clock and a different one on the second, and accumulates both products in its partial-sum register. A registered sum across the cells forms the output, so each multiplier serves two distinct coefficients. For an odd tap count, the centre coefficient multiplies the unfolded middle sample on an otherwise idle multiplier phase.

Both stream sides use valid/ready. A transfer happens on a rising edge where valid and ready are both high. When the output holds a result that the consumer has not taken (`m_valid` high, `m_ready` low), the whole pipeline freezes and `s_ready` drops in that same cycle. The output data stays unchanged until it is taken. At any other time `s_ready` is high, so an unstalled producer may push a sample every clock.

Top module: `sym_fold_fir`

## Requirements
- R1: With accepted samples numbered x[0], x[1], ... from reset, the block emits output k equal to the sum over i from 0 to TAPS-1 of h[i]*x[2k+1-i], where samples with a negative index count as zero.
- R2: For the mirror kind (KIND_MIR), h[i] = h[TAPS-1-i] = c[i] for i < ceil(TAPS/2). Here c[i] is the signed CW-bit field COEF[i*CW +: CW].
- R3: For the negated-mirror kind (KIND_NEG), h[i] = c[i] and h[TAPS-1-i] = -c[i]. With an odd TAPS, the centre field c[(TAPS-1)/2] is ignored and acts as zero.
- R4: Both odd and even TAPS values give the response of R1. With odd TAPS under KIND_MIR, the centre coefficient multiplies the single middle sample.
- R5: Exactly one output is produced per two accepted samples. With no stall, `m_valid` rises three rising edges after the edge that accepts the second sample of a pair.
- R6: While `m_valid` is high and `m_ready` is low, `s_ready` is low, `m_data` holds its value, and no result is lost or repeated.
- R7: When the output register is empty or being taken, `s_ready` is high. A continuous input stream with `m_ready` held high is accepted on every clock.
- R8: Full-scale inputs (most positive and most negative DW-bit values) never overflow the pre-adder or the accumulation, for every kind.
- R9: After reset, `m_valid` is low, `s_ready` is high, and the sample history reads as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_data | input | DW | Signed input sample |
| m_valid | output | 1 | Filtered sample valid |
| m_ready | input | 1 | Consumer takes the filtered sample |
| m_data | output | OW | Signed filtered sample |

## Verification
Two events can land on the same clock edge. One is the output being taken while the second sample of a new pair is accepted. The other is a pending result arriving at a full output register while the consumer holds back. The main stream drives `m_ready` low on every third cycle while samples keep coming. This lines up pops, stalls and pair completions in varied phases. Every delivered value is compared with a direct-form sum over the bench's record of accepted samples, so a value that is lost, repeated or shifted by a stall shows up as a wrong output. A separate run keeps `m_ready` low until the pipeline stops. It checks that `s_ready` falls and `m_data` holds, and then that the delayed results still come out correct.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
  typedef enum logic {KIND_MIR = 1'b0, KIND_NEG = 1'b1} fold_kind_e;

  // number of multiplier cells: unique coefficients split over two phases
  function automatic int cells_for(input int taps);
    return (((taps + 1) / 2) + 1) / 2;
  endfunction
endpackage

// File: rtl/ffa_fold_stage.sv
module ffa_fold_stage import ffa_pkg::*; #(
  parameter int TAPS = 7,
  parameter int DW = 12,
  parameter fold_kind_e KIND = KIND_MIR,
  localparam int FW = DW + 1,
  localparam int U = (TAPS + 1) / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 push,
  input  logic                 pair,
  input  logic signed [DW-1:0] din,
  output logic signed [FW-1:0] fold_q [U]
);
  localparam int NF = TAPS / 2;
  localparam bit HAS_MID = (TAPS % 2) == 1;

  logic signed [DW-1:0] tap [TAPS-1];
  logic signed [DW-1:0] win [TAPS];
  logic signed [FW-1:0] fold_d [U];

  // history line: win[i] is the sample accepted i pushes before din
  assign win[0] = din;
  for (genvar i = 1; i < TAPS; i++) begin : g_win
    assign win[i] = tap[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS-1; i++) tap[i] <= '0;
    end else if (en && push) begin
      tap[0] <= din;
      for (int i = 1; i < TAPS-1; i++) tap[i] <= tap[i-1];
    end
  end

  // pre-adder / pre-subtractor, one bit wider than the samples
  for (genvar p = 0; p < NF; p++) begin : g_fold
    logic signed [FW-1:0] a_x, b_x;
    assign a_x = {win[p][DW-1], win[p]};
    assign b_x = {win[TAPS-1-p][DW-1], win[TAPS-1-p]};
    if (KIND == KIND_MIR) begin : g_add
      assign fold_d[p] = a_x + b_x;
    end else begin : g_sub
      assign fold_d[p] = a_x - b_x;
    end
  end

  if (HAS_MID) begin : g_mid
    if (KIND == KIND_MIR) begin : g_keep
      assign fold_d[NF] = {win[NF][DW-1], win[NF]};
    end else begin : g_zero
      assign fold_d[NF] = '0;
    end
  end

  // snapshot of the folded window, taken with the second sample of a pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < U; i++) fold_q[i] <= '0;
    end else if (en && pair) begin
      for (int i = 0; i < U; i++) fold_q[i] <= fold_d[i];
    end
  end

  if (HAS_MID && KIND == KIND_NEG) begin : g_chk_mid
    p_mid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fold_q[NF] == '0);
  end

  p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tap[0]));
endmodule

// File: rtl/ffa_cell.sv
module ffa_cell #(
  parameter int FW = 13,
  parameter int CW = 8,
  parameter logic signed [CW-1:0] CE = '0,
  parameter logic signed [CW-1:0] CO = '0,
  localparam int PW = FW + CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 ld,
  input  logic                 acc,
  input  logic signed [FW-1:0] fe,
  input  logic signed [FW-1:0] fo,
  output logic signed [PW-1:0] psum
);
  logic signed [FW-1:0]    opnd;
  logic signed [CW-1:0]    coef;
  logic signed [FW+CW-1:0] prod;

  // phase select: first clock takes the even pair, second the odd pair
  assign opnd = acc ? fo : fe;
  assign coef = acc ? CO : CE;
  assign prod = opnd * coef;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psum <= '0;
    end else if (en) begin
      if (ld) psum <= PW'(prod);
      else if (acc) psum <= psum + PW'(prod);
    end
  end

  p_psum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(psum));
endmodule

// File: rtl/sym_fold_fir.sv
module sym_fold_fir import ffa_pkg::*; #(
  parameter int TAPS = 7,
  parameter int DW = 12,
  parameter int CW = 8,
  parameter fold_kind_e KIND = KIND_MIR,
  parameter logic [((TAPS+1)/2)*CW-1:0] COEF = 32'h02FD0501,
  localparam int OW = DW + CW + 3 + $clog2(cells_for(TAPS))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [OW-1:0] m_data
);
  localparam int U  = (TAPS + 1) / 2;
  localparam int M  = cells_for(TAPS);
  localparam int FW = DW + 1;
  localparam int PW = FW + CW + 1;

  logic en, take, odd_q, pair, c0, c1, c2;
  logic signed [FW-1:0] fold_q [U];
  logic signed [PW-1:0] psum [M];
  logic signed [OW-1:0] total;

  assign en      = !(m_valid && !m_ready);
  assign s_ready = en;
  assign take    = s_valid && en;
  assign pair    = take && odd_q;

  ffa_fold_stage #(.TAPS(TAPS), .DW(DW), .KIND(KIND)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(en), .push(take), .pair(pair),
    .din(s_data), .fold_q(fold_q)
  );

  for (genvar j = 0; j < M; j++) begin : g_cell
    localparam int E = 2 * j;
    localparam int O = 2 * j + 1;
    logic signed [FW-1:0] fo_j;
    if (O < U) begin : g_two
      assign fo_j = fold_q[O];
      ffa_cell #(.FW(FW), .CW(CW), .CE(COEF[E*CW +: CW]), .CO(COEF[O*CW +: CW])) u_cell (
        .clk(clk), .rst_n(rst_n), .en(en), .ld(c0), .acc(c1),
        .fe(fold_q[E]), .fo(fo_j), .psum(psum[j])
      );
    end else begin : g_one
      assign fo_j = '0;
      ffa_cell #(.FW(FW), .CW(CW), .CE(COEF[E*CW +: CW]), .CO('0)) u_cell (
        .clk(clk), .rst_n(rst_n), .en(en), .ld(c0), .acc(c1),
        .fe(fold_q[E]), .fo(fo_j), .psum(psum[j])
      );
    end
  end

  always_comb begin
    total = '0;
    for (int j = 0; j < M; j++) total = total + {{(OW-PW){psum[j][PW-1]}}, psum[j]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= 1'b0; c0 <= 1'b0; c1 <= 1'b0; c2 <= 1'b0;
      m_valid <= 1'b0; m_data <= '0;
    end else if (en) begin
      if (take) odd_q <= ~odd_q;
      c0 <= pair;
      c1 <= c0;
      c2 <= c1;
      if (c2) begin
        m_data  <= total;
        m_valid <= 1'b1;
      end else begin
        m_valid <= 1'b0;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_snapshot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    c0 |-> !pair);
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(c2));
endmodule

// File: tb/sym_fold_fir_tb_top.sv
`timescale 1ns/1ps
module sym_fold_fir_tb_top;
  import ffa_pkg::*;

  localparam logic [31:0] CSET = {8'd2, 8'hFD, 8'd5, 8'd1};
  localparam int NS = 24;
  // impulse, ramp, then full-scale swings (R8)
  localparam logic signed [11:0] STIM [NS] = '{
    12'sd1, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0,
    12'sd1, 12'sd2, 12'sd3, 12'sd4, 12'sd5, 12'sd6, 12'sd7, 12'sd8,
    12'sd2047, -12'sd2048, 12'sd2047, -12'sd2048, -12'sd2048, 12'sd2047, 12'sd100, -12'sd100};

  logic clk = 0, rst_n = 0, s_valid = 0, m_ready = 1;
  logic signed [11:0] s_data = '0;
  logic mv [4];
  logic sr [4];
  logic signed [23:0] md [4];

  int nchk = 0, nerr = 0, nacc = 0, stalls = 0, cyc = 0;
  int oc [4];
  bit done = 0, bp = 0;
  logic signed [11:0] hist [64];

  always #10 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_dut
    sym_fold_fir #(.TAPS((g % 2 == 0) ? 7 : 8), .DW(12), .CW(8),
      .KIND(g >= 2 ? KIND_NEG : KIND_MIR), .COEF(CSET)) dut_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(sr[g]),
      .s_data(s_data), .m_valid(mv[g]), .m_ready(m_ready), .m_data(md[g]));
  end

  function automatic longint ref_y(input int g, input int n);
    int len, m, k;
    bit neg;
    longint acc, c, x;
    len = (g % 2 == 0) ? 7 : 8;
    neg = (g >= 2);
    acc = 0;
    for (int i = 0; i < len; i++) begin
      m = (i < len-1-i) ? i : len-1-i;
      c = longint'($signed(CSET[m*8 +: 8]));
      if (neg && i > len-1-i) c = -c;
      if (neg && i == len-1-i) c = 0;
      k = n - i;
      x = (k >= 0 && k < nacc) ? longint'(hist[k]) : 0;
      acc += c * x;
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #3;
    rst_n = 0; s_valid = 0; nacc = 0;
    for (int g = 0; g < 4; g++) oc[g] = 0;
    repeat (2) @(posedge clk);
    #3 rst_n = 1;
  endtask

  task automatic send(input logic signed [11:0] x);
    @(negedge clk);
    s_valid = 1; s_data = x; #1;
    while (!sr[0]) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk);
    hist[nacc] = x;
    nacc++;
  endtask

  // consumer side back-pressure pattern
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    if (bp) m_ready = (cyc % 3 != 0);
  end

  // output monitor: each delivered value against the direct-form sum (R1)
  string tagn [4] = '{"R1 R2 R4 odd mirror", "R1 R2 R4 even mirror",
                      "R1 R3 R4 odd negmirror", "R1 R3 R4 even negmirror"};
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int g = 0; g < 4; g++) begin
        if (mv[g] && m_ready) begin
          chk(longint'(md[g]) == ref_y(g, 2*oc[g]+1), tagn[g], longint'(md[g]), ref_y(g, 2*oc[g]+1));
          oc[g]++;
        end
      end
    end
  end

  initial begin
    int cnt;
    logic signed [23:0] cap;
    do_reset();
    @(negedge clk);
    for (int g = 0; g < 4; g++) begin
      chk(!mv[g], "R9 m_valid after reset", longint'(mv[g]), 0);
      chk(sr[g], "R7 R9 s_ready after reset", longint'(sr[g]), 1);
    end

    // table walk with intermittent back-pressure (R1..R4, R8)
    bp = 1;
    for (int i = 0; i < NS; i++) send(STIM[i]);
    @(negedge clk); s_valid = 0;
    bp = 0;
    @(posedge clk); #3 m_ready = 1;
    repeat (12) @(posedge clk);
    chk(oc[0] == NS/2, "R5 output count", oc[0], NS/2);

    // latency and clean history after reset, full-scale pair (R5 R8 R9)
    do_reset();
    send(12'sd2047);
    send(-12'sd2048);
    @(negedge clk); s_valid = 0;
    cnt = 0;
    while (!mv[0] && cnt < 10) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 3, "R5 latency", cnt, 3);
    for (int g = 0; g < 4; g++)
      chk(longint'(md[g]) == ref_y(g, 1), "R8 R9 full-scale first output", longint'(md[g]), ref_y(g, 1));

    // held output (R6)
    do_reset();
    m_ready = 0;
    fork
      begin
        for (int i = 0; i < 8; i++) send(STIM[8+i]);
        @(negedge clk); s_valid = 0;
      end
      begin
        repeat (10) @(negedge clk);
        chk(mv[0] && !sr[0], "R6 stall asserted", longint'(sr[0]), 0);
        cap = md[0];
        repeat (3) @(negedge clk);
        chk(md[0] == cap, "R6 data held", longint'(md[0]), longint'(cap));
        chk(!sr[0], "R6 ready held low", longint'(sr[0]), 0);
        @(posedge clk); #3 m_ready = 1;
      end
    join
    repeat (12) @(posedge clk);
    chk(oc[0] == 4, "R5 R6 count after stall", oc[0], 4);

    // full-rate acceptance (R7)
    do_reset();
    stalls = 0;
    for (int i = 0; i < 10; i++) send(STIM[14+i]);
    @(negedge clk); s_valid = 0;
    chk(stalls == 0, "R7 no input stalls", stalls, 0);
    repeat (12) @(posedge clk);
    chk(oc[3] == 5, "R5 R7 count", oc[3], 5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule